// File: doc/BRIEF.md
# Address and Data Value Watchpoint

This unit observes the load and store traffic of a processor's data port and raises a trap request when an access meets a programmed condition. The condition can look at the physical address, at the data value being loaded or stored, or at both. Each comparison has its own bit mask, so one setting can cover an aligned address range or a partial value pattern. Because the address compared is the physical one, a hit occurs whatever virtual address the access was issued from.

A set of select bits limits watching to loads, to stores, or to both. When an access matches, the unit drives a registered trap pulse for one cycle. Alongside it, a two-bit source field reports which comparison caused the trap. Downstream control logic uses the pulse to hand execution to a handler. That handler may enter a special execution mode. Vectoring and mode switching are done outside this block.

The asynchronous reset input is released through a two-stage synchronizer. The block therefore leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `access_watch`

## Requirements
- R1: While reset is applied, and until the first access after reset, `trap_req` is 0 and `trap_src` is 2'b00.
- R2: A cycle with `acc_valid` low never produces a trap. A cycle with `cfg_enable` low never produces a trap.
- R3: A matching access presented at a rising edge drives `trap_req` high for exactly the following cycle. Matching accesses on consecutive cycles produce consecutive pulses. `trap_req` returns to 0 after the last of them.
- R4: The address compare is met when `acc_addr` and `cfg_addr` agree on every bit where `cfg_addr_mask` is 1. Bits where the mask is 0 are ignored.
- R5: The value compare is met when `acc_data` and `cfg_value` agree on every bit where `cfg_value_mask` is 1. Bits where the mask is 0 are ignored.
- R6: `cfg_mode` selects how the compares combine: 2'b00 uses the address compare alone, 2'b01 the value compare alone, 2'b10 requires both, and 2'b11 accepts either.
- R7: `acc_is_store` is 1 for a store and 0 for a load. A store can trap only when `cfg_watch_st` is 1, and a load only when `cfg_watch_ld` is 1.
- R8: `trap_src` is valid in the same cycle as `trap_req`. Bit 0 reports the address compare and bit 1 the value compare. Only compares that the mode uses can be reported. The field is 2'b00 whenever `trap_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one per load or store |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_data | input | DATA_W | Value loaded or stored |
| cfg_enable | input | 1 | Watchpoint enable |
| cfg_mode | input | 2 | Compare combination mode |
| cfg_addr | input | ADDR_W | Address to match |
| cfg_addr_mask | input | ADDR_W | Address bits taking part in the compare |
| cfg_value | input | DATA_W | Value to match |
| cfg_value_mask | input | DATA_W | Value bits taking part in the compare |
| cfg_watch_ld | input | 1 | Watch loads |
| cfg_watch_st | input | 1 | Watch stores |
| trap_req | output | 1 | One-cycle trap pulse |
| trap_src | output | 2 | Match source: bit 0 address, bit 1 value |

## Verification
The bench builds the unit with a 20-bit address and a 16-bit value. These unequal widths show that the two comparators are sized from their own parameters and never share a width. At this size, each address and value pattern can be chosen so that it differs only inside or only outside the mask. That makes every mask boundary and every mode combination reachable with a few accesses.

// File: rtl/access_watch_pkg.sv
package access_watch_pkg;

  typedef enum logic [1:0] {
    WM_ADDR   = 2'b00,
    WM_VALUE  = 2'b01,
    WM_BOTH   = 2'b10,
    WM_EITHER = 2'b11
  } wmode_e;

  localparam int SRC_ADDR_BIT  = 0;
  localparam int SRC_VALUE_BIT = 1;
  localparam int SRC_W         = 2;

endpackage

// File: rtl/aw_rst_sync.sv
module aw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/aw_masked_eq.sv
module aw_masked_eq #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [W-1:0] care,
  output logic         equal
);
  logic [W-1:0] miss;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign miss[i] = care[i] & (lhs[i] ^ rhs[i]);
  end

  assign equal = ~|miss;
endmodule

// File: rtl/aw_match_combine.sv
module aw_match_combine
  import access_watch_pkg::*;
(
  input  logic             strobe,
  input  logic             enable,
  input  logic             is_store,
  input  logic             watch_ld,
  input  logic             watch_st,
  input  logic [1:0]       mode,
  input  logic             addr_hit,
  input  logic             value_hit,
  output logic             fire,
  output logic [SRC_W-1:0] source
);
  wmode_e           mode_e;
  logic             kind_ok;
  logic             cond;
  logic [SRC_W-1:0] used;

  always_comb begin
    mode_e  = wmode_e'(mode);
    kind_ok = is_store ? watch_st : watch_ld;
    cond    = 1'b0;
    used    = '0;
    unique case (mode_e)
      WM_ADDR: begin
        cond               = addr_hit;
        used[SRC_ADDR_BIT] = 1'b1;
      end
      WM_VALUE: begin
        cond                = value_hit;
        used[SRC_VALUE_BIT] = 1'b1;
      end
      WM_BOTH: begin
        cond = addr_hit & value_hit;
        used = '1;
      end
      WM_EITHER: begin
        cond = addr_hit | value_hit;
        used = '1;
      end
      default: begin
        cond = 1'b0;
        used = '0;
      end
    endcase
    fire   = strobe & enable & kind_ok & cond;
    source = '0;
    if (fire) begin
      source[SRC_ADDR_BIT]  = addr_hit  & used[SRC_ADDR_BIT];
      source[SRC_VALUE_BIT] = value_hit & used[SRC_VALUE_BIT];
    end
  end
endmodule

// File: rtl/access_watch.sv
module access_watch
  import access_watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_addr_mask,
  input  logic [DATA_W-1:0] cfg_value,
  input  logic [DATA_W-1:0] cfg_value_mask,
  input  logic              cfg_watch_ld,
  input  logic              cfg_watch_st,
  output logic              trap_req,
  output logic [1:0]        trap_src
);
  logic             rst_n_int;
  logic             addr_hit;
  logic             value_hit;
  logic             fire;
  logic [SRC_W-1:0] src_comb;
  logic             trap_d, trap_q;
  logic [SRC_W-1:0] src_d, src_q;
  logic             upd_en;

  aw_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  aw_masked_eq #(.W(ADDR_W)) u_addr_cmp (
    .lhs   (acc_addr),
    .rhs   (cfg_addr),
    .care  (cfg_addr_mask),
    .equal (addr_hit)
  );

  aw_masked_eq #(.W(DATA_W)) u_value_cmp (
    .lhs   (acc_data),
    .rhs   (cfg_value),
    .care  (cfg_value_mask),
    .equal (value_hit)
  );

  aw_match_combine u_comb (
    .strobe    (acc_valid),
    .enable    (cfg_enable),
    .is_store  (acc_is_store),
    .watch_ld  (cfg_watch_ld),
    .watch_st  (cfg_watch_st),
    .mode      (cfg_mode),
    .addr_hit  (addr_hit),
    .value_hit (value_hit),
    .fire      (fire),
    .source    (src_comb)
  );

  // next state: register loads on a strobe, or to clear a pulse
  always_comb begin
    upd_en = acc_valid | trap_q;
    trap_d = fire;
    src_d  = src_comb;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      trap_q <= 1'b0;
      src_q  <= '0;
    end else if (upd_en) begin
      trap_q <= trap_d;
      src_q  <= src_d;
    end
  end

  assign trap_req = trap_q;
  assign trap_src = src_q;
endmodule

// File: rtl/access_watch_chk.sv
module access_watch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_is_store,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_data,
  input logic              cfg_enable,
  input logic [1:0]        cfg_mode,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [ADDR_W-1:0] cfg_addr_mask,
  input logic [DATA_W-1:0] cfg_value,
  input logic [DATA_W-1:0] cfg_value_mask,
  input logic              cfg_watch_ld,
  input logic              cfg_watch_st,
  input logic              trap_req,
  input logic [1:0]        trap_src
);
  // R2
  trap_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(acc_valid) && $past(cfg_enable)));

  // R4
  addr_src_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_src[0] |-> ((($past(acc_addr) ^ $past(cfg_addr)) & $past(cfg_addr_mask)) == '0));

  // R5
  value_src_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_src[1] |-> ((($past(acc_data) ^ $past(cfg_value)) & $past(cfg_value_mask)) == '0));

  // R6
  addr_mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && $past(cfg_mode) == 2'b00) |-> trap_src == 2'b01);

  // R6
  both_mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && $past(cfg_mode) == 2'b10) |-> trap_src == 2'b11);

  // R7
  store_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && $past(acc_is_store)) |-> $past(cfg_watch_st));

  // R7
  load_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !$past(acc_is_store)) |-> $past(cfg_watch_ld));

  // R8
  src_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_src != 2'b00));

  // R8
  src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_src == 2'b00));
endmodule

bind access_watch access_watch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_access_watch.sv
`timescale 1ns/1ps
module sim_access_watch;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid, acc_is_store;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  logic          cfg_enable;
  logic [1:0]    cfg_mode;
  logic [AW-1:0] cfg_addr, cfg_addr_mask;
  logic [DW-1:0] cfg_value, cfg_value_mask;
  logic          cfg_watch_ld, cfg_watch_st;
  logic          trap_req;
  logic [1:0]    trap_src;

  int errors = 0;
  int checks = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  access_watch #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_addr(acc_addr), .acc_data(acc_data), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_addr(cfg_addr), .cfg_addr_mask(cfg_addr_mask),
    .cfg_value(cfg_value), .cfg_value_mask(cfg_value_mask),
    .cfg_watch_ld(cfg_watch_ld), .cfg_watch_st(cfg_watch_st),
    .trap_req(trap_req), .trap_src(trap_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] mode, input logic [AW-1:0] a, input logic [AW-1:0] am,
                       input logic [DW-1:0] v, input logic [DW-1:0] vm, input logic ld, input logic st);
    @(negedge clk);
    cfg_enable = 1'b1; cfg_mode = mode; cfg_addr = a; cfg_addr_mask = am;
    cfg_value = v; cfg_value_mask = vm; cfg_watch_ld = ld; cfg_watch_st = st;
  endtask

  // drive one access, then look at the outputs one cycle later
  task automatic access(input string req, input logic st, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic exp_trap, input logic [1:0] exp_src);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = st; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " trap"}, 32'(trap_req), 32'(exp_trap));
    check({req, " src"}, 32'(trap_src), 32'(exp_src));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; acc_valid = 1'b0; acc_is_store = 1'b0; acc_addr = '0; acc_data = '0;
    cfg_enable = 1'b0; cfg_mode = 2'b00; cfg_addr = '0; cfg_addr_mask = '0;
    cfg_value = '0; cfg_value_mask = '0; cfg_watch_ld = 1'b0; cfg_watch_st = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset trap", 32'(trap_req), 0);
    check("R1 reset src", 32'(trap_src), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-reset trap", 32'(trap_req), 0);
  endtask

  task automatic t_addr;
    setup(2'b00, 20'h12340, 20'hFFFFF, 16'h0, 16'h0, 1'b1, 1'b1);
    access("R6 addr exact", 1'b0, 20'h12340, 16'h5555, 1'b1, 2'b01);
    access("R6 addr miss", 1'b0, 20'h12341, 16'h5555, 1'b0, 2'b00);
    setup(2'b00, 20'h12340, 20'hFFFF0, 16'h0, 16'h0, 1'b1, 1'b1);
    access("R4 masked low bits", 1'b1, 20'h1234F, 16'h0, 1'b1, 2'b01);
    access("R4 cared bit differs", 1'b1, 20'h1244F, 16'h0, 1'b0, 2'b00);
    access("R4 top bit differs", 1'b1, 20'h92340, 16'h0, 1'b0, 2'b00);
  endtask

  task automatic t_value;
    setup(2'b01, 20'h0, 20'hFFFFF, 16'hBEEF, 16'hFF00, 1'b1, 1'b1);
    access("R5 value masked hit", 1'b1, 20'h77777, 16'hBE12, 1'b1, 2'b10);
    access("R5 value cared miss", 1'b1, 20'h00000, 16'hBF12, 1'b0, 2'b00);
  endtask

  task automatic t_both;
    setup(2'b10, 20'hA0000, 20'hF0000, 16'h1234, 16'hFFFF, 1'b1, 1'b1);
    access("R6 both hit", 1'b0, 20'hA5555, 16'h1234, 1'b1, 2'b11);
    access("R6 both addr only", 1'b0, 20'hA5555, 16'h1235, 1'b0, 2'b00);
    access("R6 both value only", 1'b0, 20'hB5555, 16'h1234, 1'b0, 2'b00);
  endtask

  task automatic t_either;
    setup(2'b11, 20'hA0000, 20'hF0000, 16'h1234, 16'hFFFF, 1'b1, 1'b1);
    access("R8 either addr", 1'b0, 20'hA0001, 16'h0000, 1'b1, 2'b01);
    access("R8 either value", 1'b0, 20'h30001, 16'h1234, 1'b1, 2'b10);
    access("R8 either both", 1'b0, 20'hA0001, 16'h1234, 1'b1, 2'b11);
    access("R6 either none", 1'b0, 20'h30001, 16'h0000, 1'b0, 2'b00);
  endtask

  task automatic t_ldst;
    setup(2'b00, 20'h00100, 20'hFFFFF, 16'h0, 16'h0, 1'b1, 1'b0);
    access("R7 store ignored", 1'b1, 20'h00100, 16'h0, 1'b0, 2'b00);
    access("R7 load watched", 1'b0, 20'h00100, 16'h0, 1'b1, 2'b01);
    setup(2'b00, 20'h00100, 20'hFFFFF, 16'h0, 16'h0, 1'b0, 1'b1);
    access("R7 load ignored", 1'b0, 20'h00100, 16'h0, 1'b0, 2'b00);
    access("R7 store watched", 1'b1, 20'h00100, 16'h0, 1'b1, 2'b01);
  endtask

  task automatic t_nostrobe;
    setup(2'b00, 20'h00200, 20'hFFFFF, 16'h0, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 20'h00200;
    repeat (3) begin
      @(negedge clk);
      check("R2 no strobe", 32'(trap_req), 0);
    end
    @(negedge clk);
    cfg_enable = 1'b0;
    access("R2 disabled", 1'b0, 20'h00200, 16'h0, 1'b0, 2'b00);
    cfg_enable = 1'b1;
  endtask

  task automatic t_pulse;
    setup(2'b00, 20'h00300, 20'hFFFFF, 16'h0, 16'h0, 1'b1, 1'b1);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_store = 1'b0; acc_addr = 20'h00300;
    @(negedge clk);
    check("R3 first pulse", 32'(trap_req), 1);
    acc_addr = 20'h00300; acc_is_store = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R3 second pulse", 32'(trap_req), 1);
    @(negedge clk);
    check("R3 pulse ends", 32'(trap_req), 0);
    check("R8 src cleared", 32'(trap_src), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_addr();
        t_value();
        t_both();
        t_either();
        t_ldst();
        t_nostrobe();
        t_pulse();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule